// File: doc/BRIEF.md
# Single-Frame Transmit Buffer

This block holds exactly one outgoing Ethernet frame on its way to a MAC transmit path. The host first fills the buffer with 32-bit words and then raises a go strobe. The first word holds two things: in its low half, the payload length, which counts only the data after the 14 bytes of destination address, source address and type; in its upper two byte lanes, the first two destination-address bytes. The remaining bytes follow, packed little-endian. A final word that is only partly used carries its bytes in the low lanes.

The go strobe sets a pending bit. That bit stays high until the frame has been fully handed off or has been rejected. While it is high, host writes do nothing. During this time the block reads the stored words and presents them as a byte stream with valid, last and ready. When padding is enabled it extends a short frame with zero bytes. Alongside the stream it shows whether the downstream MAC should append a frame check sequence. At the end it gives a one-cycle done pulse, or an error pulse when the stored length does not fit the buffer.

Top module: `frame_tx_buffer`

## Requirements
- R1: After reset, `tx_pending`, `tx_valid`, `tx_done` and `tx_error` are all low.
- R2: A `host_go` strobe while not pending sets `tx_pending` at the next clock edge. It stays high until the clock edge that raises `tx_done` or `tx_error`, and it falls at that same edge.
- R3: The stream starts with bits 23:16 and then bits 31:24 of word 0. After that come words 1, 2, … in order, each sent lowest byte lane (bits 7:0) first. Exactly length field (word 0 bits 15:0) + 14 stored bytes are sent.
- R4: With `cfg_pad` high and a stored frame shorter than MIN_FRAME (default 60) bytes, zero bytes follow until the stream holds MIN_FRAME bytes. With `cfg_pad` low, or with a frame already at or above MIN_FRAME, no bytes are added.
- R5: `tx_last` is high on the final byte of the stream and on no other byte.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: Host writes are discarded while `tx_pending` is high. They change neither the stored words nor the write position.
- R8: When length + 14 exceeds 4·DEPTH_WORDS − 2 bytes (2046 at the default depth), the block sends no byte. It pulses `tx_error` for one cycle and clears `tx_pending`.
- R9: `tx_done` pulses for one cycle, in the cycle after the final byte is accepted.
- R10: `tx_fcs_append` equals the value `cfg_fcs` had at frame start, and it is shown with every byte of the stream.
- R11: Each frame is written from word 0 again. Words that were not rewritten keep the contents a previous frame left there, and the stream reads those contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for one data word |
| host_wdata | input | 32 | Data word written into the buffer |
| host_go | input | 1 | Requests transmission of the stored frame |
| cfg_pad | input | 1 | Enables zero padding to the minimum frame size |
| cfg_fcs | input | 1 | Asks the MAC to append the frame check sequence |
| tx_pending | output | 1 | Transmit request is outstanding |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_fcs_append | output | 1 | FCS append request travelling with the frame |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_error | output | 1 | One-cycle pulse: stored length invalid |

## Verification
The assertions assume that the stored words do not change while a frame is being sent, which the write lock guarantees. They also assume that downstream `tx_ready` may drop at any cycle, and that `cfg_pad` and `cfg_fcs` are stable across a frame's start. The stimulus drives the host port only at negative edges. It changes configuration only between frames. It produces stalls with a rotating ready pattern that keys off the frame length. It also throws a deliberate host write at the block mid-frame, which must be discarded. Lengths sweep every legal value of a 32-word buffer, with and without padding. Three oversize lengths are applied, as well as one frame that reuses stale words.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HDR  = 2'd2,
    ST_SEND = 2'd3
  } txb_state_e;

  localparam int HDR_BYTES = 14;
endpackage

// File: rtl/txb_store.sv
module txb_store #(
  parameter int DEPTH_WORDS = 512,
  parameter int AW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          lock,
  input  logic          clear,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam int PW = AW + 1;

  logic [31:0]   mem [DEPTH_WORDS];
  logic [PW-1:0] wptr_q;
  logic          accept;

  assign accept = wr_en && !lock && (wptr_q < PW'(DEPTH_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
    end else if (clear) begin
      wptr_q <= '0;
    end else if (accept) begin
      wptr_q <= wptr_q + PW'(1);
    end
  end

  // Plain synchronous RAM: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wptr_q[AW-1:0]] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

  // R7: the write position does not move while the buffer is locked
  assert_locked_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    lock && !clear |=> $stable(wptr_q));
endmodule

// File: rtl/txb_sender.sv
module txb_sender
  import txb_pkg::*;
#(
  parameter int AW        = 9,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2046,
  parameter int MIN_FRAME = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          cfg_pad,
  input  logic          cfg_fcs,
  input  logic [31:0]   rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          clear,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          tx_fcs_append,
  output logic          tx_done,
  output logic          tx_error
);
  localparam int TW = LEN_W + 1;

  txb_state_e    state_q;
  logic [31:0]   hold_q;
  logic [1:0]    lane_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] real_q;
  logic [TW-1:0] send_q;
  logic          fcs_q;

  logic [TW-1:0] hdr_total;
  logic          hdr_bad;
  logic          fire;
  logic [TW-1:0] cnt_nx;

  assign hdr_total = TW'(rd_data[LEN_W-1:0]) + TW'(HDR_BYTES);
  assign hdr_bad   = hdr_total > TW'(MAX_FRAME);
  assign cnt_nx    = cnt_q + TW'(1);

  assign tx_valid      = (state_q == ST_SEND);
  assign tx_last       = tx_valid && (cnt_q == send_q - TW'(1));
  assign tx_data       = (cnt_q < real_q) ? hold_q[{lane_q, 3'b000} +: 8] : 8'h00;
  assign tx_fcs_append = fcs_q && tx_valid;
  assign fire          = tx_valid && tx_ready;
  assign clear         = ((state_q == ST_HDR) && hdr_bad) || (fire && tx_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy     <= 1'b0;
      hold_q   <= '0;
      lane_q   <= '0;
      cnt_q    <= '0;
      real_q   <= '0;
      send_q   <= '0;
      fcs_q    <= 1'b0;
      rd_addr  <= '0;
      tx_done  <= 1'b0;
      tx_error <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      tx_error <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            busy    <= 1'b1;
            rd_addr <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: state_q <= ST_HDR;
        ST_HDR: begin
          if (hdr_bad) begin
            tx_error <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end else begin
            hold_q  <= rd_data;
            lane_q  <= 2'd2;
            cnt_q   <= '0;
            real_q  <= hdr_total;
            send_q  <= (cfg_pad && (hdr_total < TW'(MIN_FRAME))) ? TW'(MIN_FRAME) : hdr_total;
            fcs_q   <= cfg_fcs;
            rd_addr <= AW'(1);
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (tx_last) begin
              tx_done <= 1'b1;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_nx;
              if (cnt_nx < real_q) begin
                if (lane_q == 2'd3) begin
                  hold_q  <= rd_data;
                  lane_q  <= 2'd0;
                  rd_addr <= rd_addr + AW'(1);
                end else begin
                  lane_q <= lane_q + 2'd1;
                end
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_valid_pending_R2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && tx_last |=> tx_done && !busy);

  assert_error_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    tx_error |-> !tx_valid && !tx_done && !busy);
endmodule

// File: rtl/frame_tx_buffer.sv
module frame_tx_buffer #(
  parameter int DEPTH_WORDS = 512,
  parameter int MIN_FRAME   = 60,
  parameter int LEN_W       = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  input  logic        host_go,
  input  logic        cfg_pad,
  input  logic        cfg_fcs,
  output logic        tx_pending,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        tx_fcs_append,
  output logic        tx_done,
  output logic        tx_error
);
  localparam int AW        = $clog2(DEPTH_WORDS);
  localparam int MAX_FRAME = DEPTH_WORDS * 4 - 2;

  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          clear;

  txb_store #(
    .DEPTH_WORDS(DEPTH_WORDS),
    .AW         (AW)
  ) store_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (host_wr),
    .wr_data(host_wdata),
    .lock   (tx_pending),
    .clear  (clear),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  txb_sender #(
    .AW       (AW),
    .LEN_W    (LEN_W),
    .MAX_FRAME(MAX_FRAME),
    .MIN_FRAME(MIN_FRAME)
  ) sender_i (
    .clk          (clk),
    .rst          (rst),
    .go           (host_go),
    .cfg_pad      (cfg_pad),
    .cfg_fcs      (cfg_fcs),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .busy         (tx_pending),
    .clear        (clear),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .tx_fcs_append(tx_fcs_append),
    .tx_done      (tx_done),
    .tx_error     (tx_error)
  );
endmodule

// File: tb/frame_tx_buffer_tb_top.sv
module frame_tx_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int MAXF       = DEPTH * 4 - 2;
  localparam int MINF       = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_go = 1'b0;
  logic        cfg_pad = 1'b0;
  logic        cfg_fcs = 1'b0;
  logic        tx_pending;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_last;
  logic        tx_ready = 1'b0;
  logic        tx_fcs_append;
  logic        tx_done;
  logic        tx_error;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_tx_buffer #(
    .DEPTH_WORDS(DEPTH),
    .MIN_FRAME  (MINF)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_go      (host_go),
    .cfg_pad      (cfg_pad),
    .cfg_fcs      (cfg_fcs),
    .tx_pending   (tx_pending),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .tx_fcs_append(tx_fcs_append),
    .tx_done      (tx_done),
    .tx_error     (tx_error)
  );

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [31:0] mdl [DEPTH];
  int          mptr = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    return 8'((seed * 29 + i * 13 + 5) & 255);
  endfunction

  task automatic run_frame(input int len, input bit pad, input bit fcs, input int nw,
                           input int seed, input bit garbage);
    int          total;
    int          slen;
    bit          err_exp;
    int          idx;
    bit          fin;
    bit          stall;
    bit          gsent;
    logic [7:0]  sd;
    logic        sl;
    logic [7:0]  exp_b;
    logic [31:0] w;
    bit          rdy;
    bit          was_last;
    int          guard;
    total   = len + 14;
    err_exp = (total > MAXF);
    slen    = (pad && total < MINF) ? MINF : total;
    // fill the buffer; the model follows the write rules (R7, R11)
    for (int k = 0; k < nw; k++) begin
      if (k == 0) begin
        w = {gen(seed, 1), gen(seed, 0), 16'(len)};
      end else begin
        for (int j = 0; j < 4; j++) w[j*8 +: 8] = gen(seed, 4 * k - 2 + j);
      end
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = w;
      if (mptr < DEPTH) begin
        mdl[mptr] = w;
        mptr++;
      end
    end
    @(negedge clk);
    host_wr = 1'b0;
    cfg_pad = pad;
    cfg_fcs = fcs;
    host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    chk(tx_pending == 1'b1, "R2 pending after go", tx_pending, 1);
    idx   = 0;
    fin   = 0;
    stall = 0;
    gsent = 0;
    guard = 0;
    sd    = '0;
    sl    = 1'b0;
    while (!fin && guard < 4000) begin
      if (stall) begin
        chk(tx_valid && tx_data == sd && tx_last == sl, "R6 stalled byte held",
            {tx_valid, tx_data}, {1'b1, sd});
      end
      stall   = 0;
      host_wr = 1'b0;
      if (tx_error) begin
        chk(err_exp, "R8 error only on oversize length", 1, err_exp);
        chk(!tx_pending, "R8 pending cleared with error", tx_pending, 0);
        chk(idx == 0, "R8 no bytes before error", idx, 0);
        fin = 1;
      end else if (tx_done) begin
        chk(0, "R9 done without final byte", idx, slen);
        fin = 1;
      end else begin
        rdy      = ((cyc + len) % 4) != 3;
        tx_ready = rdy;
        if (tx_valid) begin
          if (rdy) begin
            if (idx < total) begin
              w     = mdl[(idx + 2) / 4];
              exp_b = w[((idx + 2) % 4) * 8 +: 8];
            end else begin
              exp_b = 8'h00;
            end
            chk(tx_data == exp_b, (idx < total) ? "R3 R11 stream byte" : "R4 pad byte",
                tx_data, exp_b);
            chk(tx_last == (idx == slen - 1), "R5 last flag", tx_last, idx == slen - 1);
            chk(tx_fcs_append == fcs, "R10 fcs request", tx_fcs_append, fcs);
            was_last = tx_last;
            idx++;
            if (was_last) begin
              @(negedge clk);
              tx_ready = 1'b0;
              chk(tx_done == 1'b1, "R9 done pulse", tx_done, 1);
              chk(!tx_pending, "R2 pending cleared with done", tx_pending, 0);
              chk(idx == slen, "R3 R4 byte count", idx, slen);
              chk(!err_exp, "R8 oversize frame was sent", err_exp, 0);
              fin = 1;
            end
          end else begin
            stall = 1;
            sd    = tx_data;
            sl    = tx_last;
          end
          if (garbage && !fin && idx == 4 && !gsent) begin
            host_wr    = 1'b1;   // must be discarded (R7)
            host_wdata = 32'hA5A5_5A5A;
            gsent      = 1;
          end
        end
      end
      if (!fin) @(negedge clk);
      guard++;
    end
    host_wr  = 1'b0;
    tx_ready = 1'b0;
    if (!fin) chk(0, "R2 frame never completed", guard, 0);
    if (fin && !tx_done && !tx_error) chk(0, "R9 completion pulse missing", 0, 1);
    @(negedge clk);
    chk(!tx_done && !tx_error, "R9 pulse lasts one cycle", {tx_done, tx_error}, 0);
    mptr = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_pending, "R1 pending after reset", tx_pending, 0);
    chk(!tx_valid, "R1 valid after reset", tx_valid, 0);
    chk(!tx_done && !tx_error, "R1 status after reset", {tx_done, tx_error}, 0);

    for (int l = 0; l <= 50; l++) begin
      run_frame(l, 1'b0, l[1], (l + 19) / 4, l + 7, 1'b0);
      run_frame(l, 1'b1, ~l[1], (l + 19) / 4, l + 3, 1'b0);
    end
    for (int l = 51; l <= MAXF - 14; l++) begin
      run_frame(l, l[0], l[1], (l + 19) / 4, l, 1'b0);
    end

    // R8 oversize lengths
    run_frame(MAXF - 13, 1'b0, 1'b0, 1, 11, 1'b0);
    run_frame(500, 1'b1, 1'b1, 1, 12, 1'b0);
    run_frame(65535, 1'b0, 1'b0, 1, 13, 1'b0);

    // R7 and R11: primer, then a shorter frame with a write attempt mid-stream,
    // then a header-only frame that reads the stale words
    run_frame(100, 1'b0, 1'b1, 29, 90, 1'b0);
    run_frame(40, 1'b1, 1'b0, 14, 91, 1'b1);
    run_frame(100, 1'b0, 1'b0, 1, 92, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule